// File: doc/BRIEF.md
# Prescaled Dual Down-Counter Timer

This block contains two down-counting timers. Both count on ticks from one shared prescaler. The prescaler counts down on every clock while at least one timer is enabled. When it passes zero it emits a tick and restarts from its own reload value. On each tick, an enabled timer decrements its counter.

When a timer reaches zero it underflows on the next tick. What happens then depends on its mode:
- In reload mode it restarts from its reload value.
- In stop mode it stays at zero and disables itself.

Every underflow produces a one-clock interrupt pulse for that timer.

Software reaches the block through a word-addressed register port. It can read and write each timer's counter, reload and control registers, and the prescaler's counter and reload registers. A control write can also copy the reload value straight into the counter.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset every register reads 0 and both interrupt outputs are low.
- R2: Registers sit at these byte addresses (address bits 1:0 ignored):
  - timer 0: counter 0x40, reload 0x44, control 0x48;
  - timer 1: counter 0x50, reload 0x54, control 0x58;
  - prescaler: counter 0x60, reload 0x64.

  Counter and reload registers read back what was written. Any other address reads 0.
- R3: The prescaler counts only while at least one timer is enabled. With reload N it produces one tick every N+1 clocks. With no timer enabled its counter holds its value.
- R4: Control bit 0 is the enable. While it is 1 the counter decrements by one per tick. While it is 0 the counter holds.
- R5: Control bit 1 = 1 selects reload mode. A tick that finds the counter at zero reloads it, so with prescaler reload N and timer reload R the interrupt repeats every (R+1)(N+1) clocks.
- R6: Control bit 1 = 0 selects stop mode. After underflow the counter stays at 0 and the enable bit clears, so exactly one interrupt pulse occurs.
- R7: Control bit 2 is a load command. Writing 1 copies the reload value into the counter at that write. The bit always reads as 0, and writing it as 0 leaves the counter untouched.
- R8: The interrupt output (bit 0 for timer 0, bit 1 for timer 1) is high for exactly the cycles in which a tick finds that timer enabled with its counter at zero.
- R9: The two timers run independently: one timer's settings and activity never change the other's counter or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address while bus_sel is high |
| irq | output | 2 | One-clock underflow pulse per timer |

## Verification
A prescaler that ticks at the wrong moment stretches or shrinks the interval between interrupt pulses. The error shows after one full period, so the bench measures the gap between two consecutive pulses rather than their absolute position. A counter that is wrongly held, reloaded or decremented shows up the next time it is read, or as a missing or extra interrupt within one timer period. A mode bit that is stored wrongly shows within one period, as a second pulse in stop mode or a missing repeat in reload mode.

// File: rtl/dtu_pkg.sv
// Package: shared constants for the prescaled dual timer.
// Holds the register word indices and control-bit positions that software relies on.
package dtu_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int N_TMR     = 2;
    // word index of the first timer block; each timer takes four words
    localparam int TMR_BASE  = 'h10;
    localparam int TMR_STEP  = 4;
    localparam int PRE_CNT_W = 'h18;
    localparam int PRE_RLD_W = 'h19;
    // control word bit positions
    localparam int CB_EN     = 0;
    localparam int CB_RL     = 1;
    localparam int CB_LD     = 2;
endpackage

// File: rtl/dtu_prescaler.sv
// Module: dtu_prescaler
// Shared divider. It counts down while 'run' is high and emits a one-cycle tick in the
// cycle it sits at zero, then restarts from its reload value.
// Assumes bus writes have priority over counting.
module dtu_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         wr_cnt,
    input  logic         wr_rld,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] rld_o,
    output logic         tick_o
);
    logic [W-1:0] cnt_q, rld_q;

    // Tick when running and the count has reached zero.
    always_comb tick_o = run && (cnt_q == '0);

    // Count down, restart from reload on tick, bus write wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (wr_cnt)  cnt_q <= wdata;
        else if (tick_o)  cnt_q <= rld_q;
        else if (run)     cnt_q <= cnt_q - 1'b1;
    end

    // Reload register, software written.
    always_ff @(posedge clk) begin
        if (!rst_n)      rld_q <= '0;
        else if (wr_rld) rld_q <= wdata;
    end

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;
endmodule

// File: rtl/dtu_channel.sv
// Module: dtu_channel
// One down-counting timer: counter, reload and control (enable, reload mode).
// It decrements on prescaler ticks while enabled. On a tick at zero it reloads (reload
// mode) or stays at zero and drops its enable (stop mode), pulsing irq_o.
// Assumes at most one bus write per cycle; a write has priority over counting.
module dtu_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_cnt,
    input  logic         wr_rld,
    input  logic         wr_ctl,
    input  logic [W-1:0] wdata,
    input  logic [2:0]   ctl_wdata,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] rld_o,
    output logic         en_o,
    output logic         rl_o,
    output logic         irq_o
);
    import dtu_pkg::*;

    logic [W-1:0] cnt_q, rld_q;
    logic         en_q, rl_q;
    logic         zero, uflow, load_cmd;

    // Underflow detection and load-command decode.
    always_comb begin
        zero     = (cnt_q == '0);
        uflow    = tick && en_q && zero;
        load_cmd = wr_ctl && ctl_wdata[CB_LD];
    end

    // Counter: direct write, load command, then tick-driven countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (wr_cnt)            cnt_q <= wdata;
        else if (load_cmd)          cnt_q <= rld_q;
        else if (tick && en_q) begin
            if (!zero)              cnt_q <= cnt_q - 1'b1;
            else if (rl_q)          cnt_q <= rld_q;
            else                    cnt_q <= '0;
        end
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)      rld_q <= '0;
        else if (wr_rld) rld_q <= wdata;
    end

    // Control: software sets the mode bits; stop-mode underflow clears the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            rl_q <= 1'b0;
        end else if (wr_ctl) begin
            en_q <= ctl_wdata[CB_EN];
            rl_q <= ctl_wdata[CB_RL];
        end else if (uflow && !rl_q) begin
            en_q <= 1'b0;
        end
    end

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;
    assign en_o  = en_q;
    assign rl_o  = rl_q;
    assign irq_o = uflow;
endmodule

// File: rtl/dual_timer_unit.sv
// Module: dual_timer_unit
// Top: a shared prescaler, two timer channels and the register decode and read mux.
// Assumes PRE_W < 32 and TMR_W <= 32. Register reads are combinational.
module dual_timer_unit #(
    parameter int TMR_W = 32,
    parameter int PRE_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [1:0]  irq
);
    import dtu_pkg::*;

    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0]           widx;
    logic                        wr;
    logic [N_TMR-1:0][TMR_W-1:0] cnt_all, rld_all;
    logic [N_TMR-1:0]            en_all, rl_all, irq_all;
    logic [PRE_W-1:0]            pre_cnt, pre_rld;
    logic                        tick;
    logic                        unused_bits;

    // Word index and write strobe.
    always_comb begin
        widx        = bus_addr[ADDR_W-1:2];
        wr          = bus_sel && bus_we;
        unused_bits = ^{bus_wdata[31:PRE_W], bus_addr[1:0]};
    end

    dtu_prescaler #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (|en_all),
        .wr_cnt (wr && widx == WIDX_W'(PRE_CNT_W)),
        .wr_rld (wr && widx == WIDX_W'(PRE_RLD_W)),
        .wdata  (bus_wdata[PRE_W-1:0]),
        .cnt_o  (pre_cnt),
        .rld_o  (pre_rld),
        .tick_o (tick)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_ch
        localparam int B = TMR_BASE + i * TMR_STEP;
        dtu_channel #(.W(TMR_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .wr_cnt    (wr && widx == WIDX_W'(B)),
            .wr_rld    (wr && widx == WIDX_W'(B + 1)),
            .wr_ctl    (wr && widx == WIDX_W'(B + 2)),
            .wdata     (bus_wdata[TMR_W-1:0]),
            .ctl_wdata (bus_wdata[2:0]),
            .cnt_o     (cnt_all[i]),
            .rld_o     (rld_all[i]),
            .en_o      (en_all[i]),
            .rl_o      (rl_all[i]),
            .irq_o     (irq_all[i])
        );
    end

    // Read mux: timer words, prescaler words, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            for (int i = 0; i < N_TMR; i++) begin
                if (widx == WIDX_W'(TMR_BASE + i * TMR_STEP))
                    bus_rdata = DATA_W'(cnt_all[i]);
                if (widx == WIDX_W'(TMR_BASE + i * TMR_STEP + 1))
                    bus_rdata = DATA_W'(rld_all[i]);
                if (widx == WIDX_W'(TMR_BASE + i * TMR_STEP + 2))
                    bus_rdata = DATA_W'({rl_all[i], en_all[i]});
            end
            if (widx == WIDX_W'(PRE_CNT_W)) bus_rdata = DATA_W'(pre_cnt);
            if (widx == WIDX_W'(PRE_RLD_W)) bus_rdata = DATA_W'(pre_rld);
        end
    end

    assign irq = irq_all;
endmodule

// File: rtl/dual_timer_unit_chk.sv
// Module: dual_timer_unit_chk
// Checker bound into dual_timer_unit. It watches channel state and the prescaler tick
// across cycles. Every property is disabled during reset.
module dual_timer_unit_chk #(
    parameter int TMR_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_we,
    input logic                  tick,
    input logic [1:0]            irq,
    input logic [1:0][TMR_W-1:0] cnt_all,
    input logic [1:0][TMR_W-1:0] rld_all,
    input logic [1:0]            en_all,
    input logic [1:0]            rl_all
);
    logic wr;
    assign wr = bus_sel && bus_we;

    // R3: no tick while every timer is disabled
    p_no_tick_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == 2'b00) |-> !tick);

    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R8: an interrupt only with a tick, the timer enabled and the counter at zero
        p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (tick && en_all[i] && cnt_all[i] == '0));
        // R4: a disabled timer holds its count when the bus is quiet
        p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_all[i] && !wr) |=> $stable(cnt_all[i]));
        // R4: an enabled timer drops by one per tick above zero
        p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && en_all[i] && cnt_all[i] != '0 && !wr)
            |=> cnt_all[i] == $past(cnt_all[i]) - 1'b1);
        // R5: reload-mode underflow restarts from the reload value
        p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[i] && rl_all[i] && !wr) |=> cnt_all[i] == $past(rld_all[i]));
        // R6: stop-mode underflow parks at zero with the enable cleared
        p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[i] && !rl_all[i] && !wr) |=> (cnt_all[i] == '0 && !en_all[i]));
    end
endmodule

bind dual_timer_unit dual_timer_unit_chk #(.TMR_W(TMR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .tick    (tick),
    .irq     (irq),
    .cnt_all (cnt_all),
    .rld_all (rld_all),
    .en_all  (en_all),
    .rl_all  (rl_all)
);

// File: tb/dual_timer_unit_test.sv
// Bench for dual_timer_unit: a table of interrupt-period vectors, then directed tests.
module dual_timer_unit_test;
    localparam int CLK_PERIOD = 10;
    // vector: prescaler reload, timer reload, expected interrupt period in clocks
    localparam logic [47:0] VEC [4] = '{
        {16'd0, 16'd3, 16'd4},
        {16'd1, 16'd3, 16'd8},
        {16'd4, 16'd2, 16'd15},
        {16'd2, 16'd0, 16'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    dual_timer_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Clocks from one interrupt pulse on channel ch to the next (0 on timeout).
    task automatic period(input int ch, output int n);
        int t = 0;
        n = 0;
        while (!irq[ch] && t < 2000) begin @(negedge clk); t++; end
        do begin @(negedge clk); n++; end while (!irq[ch] && n < 2000);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n, pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        foreach (VEC[k]) begin end
        for (int a = 'h40; a <= 'h64; a += 4) begin
            rd(8'(a), v);
            check("R1 reset register", v, 0);
        end
        check("R1 reset irq", {30'd0, irq}, 0);

        // R2: readback and unmapped addresses
        wr(8'h40, 32'h55AA_1234); rd(8'h40, v); check("R2 counter readback", v, 32'h55AA_1234);
        wr(8'h54, 32'h0000_00C3); rd(8'h54, v); check("R2 reload readback", v, 32'h0000_00C3);
        wr(8'h4C, 32'hFFFF_FFFF); rd(8'h4C, v); check("R2 unmapped reads 0", v, 0);
        rd(8'h5C, v); check("R2 unmapped reads 0", v, 0);

        // R3 R5 R8: interrupt periods from the vector table
        foreach (VEC[k]) begin
            wr(8'h48, 0); wr(8'h58, 0);
            wr(8'h64, 32'(VEC[k][47:32]));
            wr(8'h60, 0);
            wr(8'h44, 32'(VEC[k][31:16]));
            wr(8'h48, 32'h7);
            period(0, n);
            period(0, n);
            check("R5 interrupt period", n, 32'(VEC[k][15:0]));
        end
        rd(8'h48, v); check("R7 load bit reads 0, R5 mode kept", v, 32'h3);
        wr(8'h48, 0);

        // R6: stop mode yields one pulse, counter parks at 0, enable clears
        wr(8'h64, 0); wr(8'h60, 0);
        wr(8'h44, 2);
        wr(8'h48, 32'h5);
        pulses = 0;
        repeat (15) begin @(negedge clk); if (irq[0]) pulses++; end
        check("R6 single pulse in stop mode", pulses, 1);
        rd(8'h40, v); check("R6 counter stays 0", v, 0);
        rd(8'h48, v); check("R6 enable cleared", v, 0);

        // R7: load command with the enable off
        wr(8'h44, 9);
        wr(8'h48, 32'h4);
        rd(8'h40, v); check("R7 load copies reload", v, 9);
        rd(8'h48, v); check("R7 load bit reads 0", v, 0);

        // R9 R4: timer 1 runs while timer 0 stays disabled
        wr(8'h54, 5);
        wr(8'h58, 32'h7);
        pulses = 0;
        period(1, n);
        check("R9 timer 1 period", n, 6);
        repeat (12) begin @(negedge clk); if (irq[0]) pulses++; end
        check("R9 timer 0 silent", pulses, 0);
        rd(8'h40, v); check("R4 disabled counter holds", v, 9);
        wr(8'h48, 0);
        rd(8'h40, v); check("R7 load bit 0 has no effect", v, 9);

        // R3: prescaler holds with no timer enabled
        wr(8'h58, 0);
        wr(8'h60, 5);
        repeat (6) @(negedge clk);
        rd(8'h60, v); check("R3 prescaler holds when idle", v, 5);
        check("R8 no irq when idle", {30'd0, irq}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule